// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line back into characters. It runs from the system clock and moves forward only on a one-cycle enable that pulses sixteen times per bit period. A low level seen while the line is idle counts as a candidate start. The candidate is confirmed half a bit later; if the line has gone high again by then, it was a glitch and is dropped. After a confirmed start, every further bit is sampled once, in the middle of its bit period.

Each character has a programmable length of five to eight bits and an optional even or odd parity bit, followed by one stop bit. When the stop bit is sampled, the block pulses a valid strobe together with the character and its error flags. A line held low for a whole character is reported as a break, not as a framing error. After a break or a framing error, the receiver waits for the line to return high before it accepts a new start. A loopback select takes the serial input from the local transmitter output instead of the external pin.

Top module: `os_uart_rx`

## Requirements
- R1: After reset every output is 0, and the receiver ignores a low line until it has sampled the line high at least once.
- R2: A low level sampled on an idle tick is a candidate start. It is confirmed on the 8th following tick. If the line is high at that tick, the candidate is dropped and no character is produced.
- R3: Data bits are sampled every 16 ticks from the confirmed start midpoint, least significant bit first. The length code `charLen` selects 00=5, 01=6, 10=7 or 11=8 bits. Unused upper bits of `rxData` are 0.
- R4: The parity mode `parMode` selects 01=even, 10=odd, or 00/11=no parity bit. `parityErr` is set when the number of ones across the data bits and the parity bit is odd in even mode, or even in odd mode. It is never set without parity.
- R5: A low stop bit in a character that is not a break sets `frameErr`.
- R6: When start, data, parity (if enabled) and stop are all sampled low, a single character is delivered with `breakDet`=1, `rxData`=0, and `frameErr` and `parityErr` both 0.
- R7: After a framing error or a break, no new start is accepted until the line has been sampled high. A line that stays low produces no further characters.
- R8: With `loopEn`=1 the receiver uses `txLoop` and ignores `serialIn`. With `loopEn`=0 it uses `serialIn` and ignores `txLoop`.
- R9: `rxValid` is a one-cycle pulse in the clock cycle after the stop-bit sample tick. The error flags are 1 only during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulsing 16 times per bit period |
| serialIn | input | 1 | Synchronized external serial line |
| txLoop | input | 1 | Local transmitter output used in loopback |
| loopEn | input | 1 | 1 selects txLoop as the receive source |
| charLen | input | 2 | Character length code (5 to 8 bits) |
| parMode | input | 2 | Parity mode: 01 even, 10 odd, else none |
| rxValid | output | 1 | One-cycle character strobe |
| rxData | output | 8 | Received character, right aligned |
| parityErr | output | 1 | Parity mismatch, valid with rxValid |
| frameErr | output | 1 | Low stop bit, valid with rxValid |
| breakDet | output | 1 | Full-character low line, valid with rxValid |

## Verification
The assertions assume that `charLen`, `parMode` and `loopEn` stay constant while a character is in flight. The stimulus changes them only while the line has been idle-high for at least one bit period. The assertions also assume that `tick16` is a single-cycle pulse and that the line input is already synchronized. The bench pulses the tick every second clock and changes the line only at a clock low phase, on a tick boundary. Bit periods are exactly 16 ticks, so every mid-bit sample falls well inside a stable bit.

// File: rtl/os_uart_rx_pkg.sv
`timescale 1ns/1ps
package os_uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic clear;   // start confirmed: reset accumulators
    logic shift;   // sample a data bit
    logic capPar;  // sample the parity bit
    logic finish;  // sample the stop bit and deliver
  } rxStrobe_t;

  localparam int MIN_BITS = 5;
endpackage

// File: rtl/os_uart_rx_ctrl.sv
`timescale 1ns/1ps
module os_uart_rx_ctrl
  import os_uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      lineBit,
  input  logic [1:0] charLen,
  input  logic      parOn,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             midHit;
  logic             bitHit;

  assign lastIdx = IDX_W'(charLen) + IDX_W'(MIN_BITS - 1);
  assign midHit  = tick && (cnt == MID_LAST);
  assign bitHit  = tick && (cnt == BIT_LAST);

  always_comb begin
    strobe        = '0;
    strobe.clear  = (state == ST_START) && midHit && !lineBit;
    strobe.shift  = (state == ST_DATA) && bitHit;
    strobe.capPar = (state == ST_PAR) && bitHit;
    strobe.finish = (state == ST_STOP) && bitHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_WAIT;
      cnt   <= '0;
      idx   <= '0;
    end else if (tick) begin
      case (state)
        ST_WAIT: begin
          if (lineBit) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (!lineBit) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == MID_LAST) begin
            cnt   <= '0;
            idx   <= '0;
            state <= lineBit ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == BIT_LAST) begin
            cnt <= '0;
            if (idx == lastIdx) state <= parOn ? ST_PAR : ST_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == BIT_LAST) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == BIT_LAST) begin
            cnt   <= '0;
            state <= lineBit ? ST_IDLE : ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/os_uart_rx_dp.sv
`timescale 1ns/1ps
module os_uart_rx_dp
  import os_uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineBit,
  input  rxStrobe_t         strobe,
  input  logic [1:0]        charLen,
  input  logic              parOn,
  input  logic              oddMode,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakDet
);
  logic [DATA_W-1:0] shReg;
  logic              onesAcc;
  logic              parBit;
  logic              seenHigh;
  logic [DATA_W-1:0] aligned;
  logic              isBreak;

  assign aligned = shReg >> (DATA_W - (MIN_BITS + int'(charLen)));
  assign isBreak = !seenHigh && !lineBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      onesAcc   <= 1'b0;
      parBit    <= 1'b0;
      seenHigh  <= 1'b0;
      rxValid   <= 1'b0;
      rxData    <= '0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
      if (strobe.clear) begin
        shReg    <= '0;
        onesAcc  <= 1'b0;
        parBit   <= 1'b0;
        seenHigh <= 1'b0;
      end
      if (strobe.shift) begin
        shReg    <= {lineBit, shReg[DATA_W-1:1]};
        onesAcc  <= onesAcc ^ lineBit;
        seenHigh <= seenHigh | lineBit;
      end
      if (strobe.capPar) begin
        parBit   <= lineBit;
        seenHigh <= seenHigh | lineBit;
      end
      if (strobe.finish) begin
        rxValid   <= 1'b1;
        rxData    <= isBreak ? '0 : aligned;
        breakDet  <= isBreak;
        frameErr  <= !lineBit && !isBreak;
        parityErr <= !isBreak && parOn && (onesAcc ^ parBit ^ oddMode);
      end
    end
  end
endmodule

// File: rtl/os_uart_rx.sv
`timescale 1ns/1ps
module os_uart_rx
  import os_uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              serialIn,
  input  logic              txLoop,
  input  logic              loopEn,
  input  logic [1:0]        charLen,
  input  logic [1:0]        parMode,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakDet
);
  logic      lineBit;
  logic      parOn;
  logic      oddMode;
  rxStrobe_t strobe;

  assign lineBit = loopEn ? txLoop : serialIn;
  assign parOn   = (parMode == 2'b01) || (parMode == 2'b10);
  assign oddMode = (parMode == 2'b10);

  os_uart_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .lineBit (lineBit),
    .charLen (charLen),
    .parOn   (parOn),
    .strobe  (strobe)
  );

  os_uart_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineBit   (lineBit),
    .strobe    (strobe),
    .charLen   (charLen),
    .parOn     (parOn),
    .oddMode   (oddMode),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .breakDet  (breakDet)
  );
endmodule

// File: rtl/os_uart_rx_chk.sv
`timescale 1ns/1ps
module os_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        charLen,
  input logic [1:0]        parMode,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              parityErr,
  input logic              frameErr,
  input logic              breakDet
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R9
  flag_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || frameErr || breakDet) |-> rxValid);

  // R6
  break_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> (rxData == '0) && !frameErr && !parityErr);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> (5 + int'(charLen))) == '0));

  // R4
  no_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (parMode == 2'b00 || parMode == 2'b11)) |-> !parityErr);
endmodule

bind os_uart_rx os_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .charLen   (charLen),
  .parMode   (parMode),
  .rxValid   (rxValid),
  .rxData    (rxData),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .breakDet  (breakDet)
);

// File: tb/os_uart_rx_tb.sv
`timescale 1ns/1ps
module os_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       lnVal = 1'b0;
  logic       loopEn = 1'b0;
  logic [1:0] charLen = 2'b11;
  logic [1:0] parMode = 2'b00;
  logic       serialIn;
  logic       txLoop;
  logic       rxValid;
  logic [7:0] rxData;
  logic       parityErr;
  logic       frameErr;
  logic       breakDet;

  int checks = 0;
  int failures = 0;
  logic prevValid = 1'b0;
  logic [10:0] expQ[$];  // {brk, fe, pe, data}

  // the unused source is held at a level that would disturb the receiver
  assign serialIn = loopEn ? 1'b0 : lnVal;
  assign txLoop   = loopEn ? lnVal : 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  always @(negedge clk) tick16 <= rstN ? ~tick16 : 1'b0;

  os_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serialIn(serialIn),
    .txLoop(txLoop), .loopEn(loopEn), .charLen(charLen), .parMode(parMode),
    .rxValid(rxValid), .rxData(rxData), .parityErr(parityErr),
    .frameErr(frameErr), .breakDet(breakDet)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
  endtask

  task automatic driveBits(input logic b, input int nBits);
    @(negedge clk);
    lnVal = b;
    waitTicks(16 * nBits);
  endtask

  // sends one frame and queues the expected result
  task automatic sendChar(input logic [7:0] d, input logic badPar, input logic stopVal);
    int n;
    logic [7:0] dm;
    logic pb;
    logic parOn;
    n = 5 + int'(charLen);
    dm = d & 8'((1 << n) - 1);
    parOn = (parMode == 2'b01) || (parMode == 2'b10);
    pb = (^dm) ^ (parMode == 2'b10) ^ badPar;
    expQ.push_back({1'b0, ~stopVal, parOn & badPar, dm});
    driveBits(1'b0, 1);
    for (int i = 0; i < n; i++) driveBits(dm[i], 1);
    if (parOn) driveBits(pb, 1);
    driveBits(stopVal, 1);
    driveBits(1'b1, 2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid && prevValid) check(1'b0, "R9 pulse width", 2, 1);
      if (rxValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2/R7 unexpected character", int'(rxData), 0);
        end else begin
          logic [10:0] e;
          e = expQ.pop_front();
          check(rxData == e[7:0], "R3 data", int'(rxData), int'(e[7:0]));
          check(parityErr == e[8], "R4 parityErr", int'(parityErr), int'(e[8]));
          check(frameErr == e[9], "R5 frameErr", int'(frameErr), int'(e[9]));
          check(breakDet == e[10], "R6 breakDet", int'(breakDet), int'(e[10]));
        end
      end else begin
        if (parityErr || frameErr || breakDet)
          check(1'b0, "R9 flag without valid", 1, 0);
      end
      prevValid <= rxValid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check({rxValid, rxData, parityErr, frameErr, breakDet} == '0, "R1 reset outputs",
          int'({rxValid, rxData}), 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: line low straight out of reset must not start a character
    waitTicks(16 * 12);
    driveBits(1'b1, 2);

    // R3 eight-bit, no parity
    sendChar(8'hA5, 1'b0, 1'b1);
    sendChar(8'h3C, 1'b0, 1'b1);
    // R3 shorter lengths
    charLen = 2'b00; sendChar(8'hF5, 1'b0, 1'b1);
    charLen = 2'b01; sendChar(8'h2B, 1'b0, 1'b1);
    charLen = 2'b10; sendChar(8'h7F, 1'b0, 1'b1);
    charLen = 2'b11;
    // R4 parity modes
    parMode = 2'b01; sendChar(8'h96, 1'b0, 1'b1);
    sendChar(8'h97, 1'b1, 1'b1);
    parMode = 2'b10; sendChar(8'h41, 1'b0, 1'b1);
    sendChar(8'h40, 1'b1, 1'b1);
    parMode = 2'b11; sendChar(8'h81, 1'b0, 1'b1);
    parMode = 2'b00;

    // R2 false starts: short low pulses
    driveBits(1'b0, 0); waitTicks(3); driveBits(1'b1, 2);
    driveBits(1'b0, 0); waitTicks(7); driveBits(1'b1, 2);
    sendChar(8'h5A, 1'b0, 1'b1);

    // R5 framing error then R7 line stays low
    expQ.push_back({1'b0, 1'b1, 1'b0, 8'h55});
    driveBits(1'b0, 1);
    for (int i = 0; i < 8; i++) driveBits(i[0] ? 1'b0 : 1'b1, 1);
    driveBits(1'b0, 30);
    driveBits(1'b1, 2);
    sendChar(8'hC3, 1'b0, 1'b1);

    // R6 break with even parity, held well past the frame (R7)
    parMode = 2'b01;
    expQ.push_back({1'b1, 1'b0, 1'b0, 8'h00});
    driveBits(1'b0, 30);
    driveBits(1'b1, 2);
    sendChar(8'h18, 1'b0, 1'b1);
    parMode = 2'b00;

    // R8 loopback: serialIn held low is ignored
    loopEn = 1'b1;
    driveBits(1'b1, 2);
    sendChar(8'h69, 1'b0, 1'b1);
    sendChar(8'h0F, 1'b0, 1'b1);
    loopEn = 1'b0;
    driveBits(1'b1, 2);
    sendChar(8'hE1, 1'b0, 1'b1);

    waitTicks(16 * 4);
    check(expQ.size() == 0, "R3 all characters delivered", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule